// File: doc/BRIEF.md
# Bus Controller Status-Word Interrupt Logic

This block sits beside the message engine of a MIL-STD-1553 bus controller. Each time a remote terminal answers, the engine presents the returned status word together with a one-cycle strobe. The block compares the word with what the controller expected, covering the terminal address and the defined status flags, and records any discrepancy as a sticky interrupt flag. Besides the status check it records message errors reported by the terminal, message completion, and a four-bit code that the controller's IRQ instruction places straight into the flag register.

Software sees three registers through a small synchronous write / combinational read port: the latched flags (write 1 to clear), a latch-enable mask and an output-enable mask. The interrupt output is raised while any latched flag is also enabled for output. The broadcast-received bit in the status word is a special case. Its expected value is chosen per message from a configuration bit and from the mask-broadcast bit of the message control word.

Top module: `bcStatusIrq`

## Requirements
- R1: After reset all three registers read 0x0000 and `irqOut` is low.
- R2: On a `stsValid` cycle, status-set flag bit 9 is latched when status bits 15:11 differ from `cmdRtAddr`.
- R3: On a `stsValid` cycle, bit 9 is also latched when any of status bits 10, 9, 8, 3, 2, 1 or 0 is 1; status bits 7:5 never affect any flag.
- R4: With `bcastMaskEn` = 0, status bit 4 is expected to equal `ctlMaskBcast` and a mismatch latches bit 9; with `bcastMaskEn` = 1, status bit 4 is not compared.
- R5: Message-error flag bit 4 is latched on a `stsValid` cycle only when `isBcastMsg` = 0 and status bit 10 is 1.
- R6: End-of-message flag bit 3 is latched on every `msgDone` pulse.
- R7: On an `irqOpStb` cycle, flag bits 8:5 are overwritten with `irqOpParam` ANDed with enable bits 8:5; outside such cycles they change only by a clear.
- R8: A flag among bits 9:3 is latched only when the matching bit of the enable register (address 1) is 1.
- R9: Latched flags stay set until a write to address 0 with a 1 in that position; a set event in the same cycle as the clear wins.
- R10: Flag register bit 0 reads 1 exactly when any of bits 15:3 of the flag register is 1.
- R11: Enable and output-enable registers keep only bits 9:3 (others read 0, writes ignored); flag bits 15:10 and 2:1 read 0; address 3 reads 0.
- R12: `irqOut` is high exactly when some latched flag is 1 and the same bit of the output-enable register (address 2) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stsValid | input | 1 | One-cycle strobe: returned status word is present |
| stsWord | input | 16 | Returned RT status word |
| cmdRtAddr | input | 5 | RT address used in the command |
| bcastMaskEn | input | 1 | Configuration: 1 excludes the broadcast-received bit from the check |
| ctlMaskBcast | input | 1 | Control-word bit giving the expected broadcast-received value |
| isBcastMsg | input | 1 | Current message was sent to the broadcast address |
| msgDone | input | 1 | One-cycle strobe: message finished |
| irqOpStb | input | 1 | One-cycle strobe: IRQ instruction executed |
| irqOpParam | input | 4 | Low four bits of the IRQ instruction's parameter |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select: 0 flags, 1 enable, 2 output enable |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that flags change only through the strobes and the register port: `stsValid`, `msgDone` and `irqOpStb` are single-cycle pulses, and a flag can rise only in the cycle after its enable bit was already 1. The stimulus keeps to this by raising each strobe for exactly one clock and programming the enable masks in a separate write before any event. Every status pattern is applied from a cleared flag register, so each reading reflects one message alone.

// File: rtl/bcIrqPkg.sv
package bcIrqPkg;
  localparam int WORD_W = 16;
  localparam int RTA_W  = 5;
  localparam int CODE_W = 4;

  // flag register positions
  localparam int PEND_BIT  = 0;
  localparam int EOM_BIT   = 3;
  localparam int MERR_BIT  = 4;
  localparam int CODE_LSB  = 5;
  localparam int STSET_BIT = 9;
  localparam int LIVE_LO   = EOM_BIT;
  localparam int LIVE_HI   = STSET_BIT;

  // status word positions
  localparam int SW_MERR   = 10;
  localparam int SW_BCR    = 4;
  localparam int SW_RSV_LO = 5;
  localparam int SW_RSV_HI = 7;

  typedef enum logic [1:0] {
    REG_FLAGS = 2'd0,
    REG_EN    = 2'd1,
    REG_OUTEN = 2'd2,
    REG_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              setStatus;
    logic              setMsgErr;
    logic              setEom;
    logic              loadCode;
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] clrMask;
    logic              wrEn;
    logic              wrOutEn;
    logic [WORD_W-1:0] wrData;
  } ctlStb_t;
endpackage

// File: rtl/bcStsCheck.sv
module bcStsCheck
  import bcIrqPkg::*;
#(
  parameter int WIDTH     = WORD_W,
  parameter int RTA_WIDTH = RTA_W
) (
  input  logic [WIDTH-1:0]     stsWord,
  input  logic [RTA_WIDTH-1:0] cmdRtAddr,
  input  logic                 bcastMaskEn,
  input  logic                 ctlMaskBcast,
  output logic                 statusBad
);
  localparam int FLD_W = WIDTH - RTA_WIDTH;

  logic [FLD_W-1:0] mism;
  logic             addrMiss;

  assign addrMiss = stsWord[WIDTH-1 -: RTA_WIDTH] != cmdRtAddr;

  // one comparator per status flag position; reserved positions drop out
  for (genvar b = 0; b < FLD_W; b++) begin : g_bit
    if (b == SW_BCR) begin : g_bcr
      assign mism[b] = !bcastMaskEn && (stsWord[b] != ctlMaskBcast);
    end else if (b >= SW_RSV_LO && b <= SW_RSV_HI) begin : g_rsv
      assign mism[b] = stsWord[b] & 1'b0;
    end else begin : g_zero
      assign mism[b] = stsWord[b];
    end
  end

  assign statusBad = addrMiss || (|mism);
endmodule

// File: rtl/bcIrqCtrl.sv
module bcIrqCtrl
  import bcIrqPkg::*;
#(
  parameter int WIDTH      = WORD_W,
  parameter int CODE_WIDTH = CODE_W
) (
  input  logic                  stsValid,
  input  logic                  statusBad,
  input  logic                  stsMerr,
  input  logic                  isBcastMsg,
  input  logic                  msgDone,
  input  logic                  irqOpStb,
  input  logic [CODE_WIDTH-1:0] irqOpParam,
  input  logic                  regWe,
  input  logic [1:0]            regAddr,
  input  logic [WIDTH-1:0]      regWdata,
  output ctlStb_t               stb
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    stb           = '0;
    stb.setStatus = stsValid && statusBad;
    stb.setMsgErr = stsValid && stsMerr && !isBcastMsg;
    stb.setEom    = msgDone;
    stb.loadCode  = irqOpStb;
    stb.code      = irqOpParam;
    stb.wrData    = regWdata;
    if (regWe) begin
      unique case (sel)
        REG_FLAGS: stb.clrMask = regWdata;
        REG_EN:    stb.wrEn    = 1'b1;
        REG_OUTEN: stb.wrOutEn = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/bcIrqRegs.sv
module bcIrqRegs
  import bcIrqPkg::*;
#(
  parameter int WIDTH      = WORD_W,
  parameter int CODE_WIDTH = CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [1:0]       regAddr,
  output logic [WIDTH-1:0] regRdata,
  output logic             irqOut
);
  localparam logic [WIDTH-1:0] LIVE_MASK =
    WIDTH'(((1 << (LIVE_HI + 1)) - 1) ^ ((1 << LIVE_LO) - 1));

  logic [WIDTH-1:0] flagQ, flagD, enQ, outEnQ, setVec;
  logic             pending;
  regSel_e          sel;

  always_comb begin
    setVec            = '0;
    setVec[STSET_BIT] = stb.setStatus;
    setVec[MERR_BIT]  = stb.setMsgErr;
    setVec[EOM_BIT]   = stb.setEom;
    setVec            = setVec & enQ;
    flagD             = (flagQ & ~stb.clrMask) | setVec;
    if (stb.loadCode)
      flagD[CODE_LSB +: CODE_WIDTH] = stb.code & enQ[CODE_LSB +: CODE_WIDTH];
    flagD = flagD & LIVE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      enQ    <= '0;
      outEnQ <= '0;
    end else begin
      flagQ <= flagD;
      if (stb.wrEn)    enQ    <= stb.wrData & LIVE_MASK;
      if (stb.wrOutEn) outEnQ <= stb.wrData & LIVE_MASK;
    end
  end

  assign pending = |flagQ[WIDTH-1:LIVE_LO];
  assign sel     = regSel_e'(regAddr);

  always_comb begin
    regRdata = '0;
    unique case (sel)
      REG_FLAGS: begin
        regRdata           = flagQ;
        regRdata[PEND_BIT] = pending;
      end
      REG_EN:    regRdata = enQ;
      REG_OUTEN: regRdata = outEnQ;
      default:   regRdata = '0;
    endcase
  end

  assign irqOut = |(flagQ & outEnQ);

  for (genvar k = LIVE_LO; k <= LIVE_HI; k++) begin : g_chk
    // R8
    en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[k]) |-> $past(enQ[k]));
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(flagQ[k]) && !$past(stb.clrMask[k]) && !$past(stb.loadCode)) |-> flagQ[k]);
  end

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.loadCode) && ($past(stb.clrMask[CODE_LSB +: CODE_WIDTH]) == '0))
      |-> $stable(flagQ[CODE_LSB +: CODE_WIDTH]));
endmodule

// File: rtl/bcStatusIrq.sv
module bcStatusIrq
  import bcIrqPkg::*;
#(
  parameter int WIDTH      = WORD_W,
  parameter int RTA_WIDTH  = RTA_W,
  parameter int CODE_WIDTH = CODE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stsValid,
  input  logic [WIDTH-1:0]      stsWord,
  input  logic [RTA_WIDTH-1:0]  cmdRtAddr,
  input  logic                  bcastMaskEn,
  input  logic                  ctlMaskBcast,
  input  logic                  isBcastMsg,
  input  logic                  msgDone,
  input  logic                  irqOpStb,
  input  logic [CODE_WIDTH-1:0] irqOpParam,
  input  logic                  regWe,
  input  logic [1:0]            regAddr,
  input  logic [WIDTH-1:0]      regWdata,
  output logic [WIDTH-1:0]      regRdata,
  output logic                  irqOut
);
  logic    statusBad;
  ctlStb_t stb;

  bcStsCheck #(.WIDTH(WIDTH), .RTA_WIDTH(RTA_WIDTH)) uCheck (
    .stsWord     (stsWord),
    .cmdRtAddr   (cmdRtAddr),
    .bcastMaskEn (bcastMaskEn),
    .ctlMaskBcast(ctlMaskBcast),
    .statusBad   (statusBad)
  );

  bcIrqCtrl #(.WIDTH(WIDTH), .CODE_WIDTH(CODE_WIDTH)) uCtrl (
    .stsValid  (stsValid),
    .statusBad (statusBad),
    .stsMerr   (stsWord[SW_MERR]),
    .isBcastMsg(isBcastMsg),
    .msgDone   (msgDone),
    .irqOpStb  (irqOpStb),
    .irqOpParam(irqOpParam),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .stb       (stb)
  );

  bcIrqRegs #(.WIDTH(WIDTH), .CODE_WIDTH(CODE_WIDTH)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .regAddr (regAddr),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(stsValid || msgDone || irqOpStb || regWe));
endmodule

// File: tb/bcStatusIrq_test.sv
`timescale 1ns/1ps
module bcStatusIrq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stsValid = 1'b0;
  logic [15:0] stsWord = '0;
  logic [4:0]  cmdRtAddr = '0;
  logic        bcastMaskEn = 1'b0;
  logic        ctlMaskBcast = 1'b0;
  logic        isBcastMsg = 1'b0;
  logic        msgDone = 1'b0;
  logic        irqOpStb = 1'b0;
  logic [3:0]  irqOpParam = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcStatusIrq uut (
    .clk(clk), .rstN(rstN), .stsValid(stsValid), .stsWord(stsWord),
    .cmdRtAddr(cmdRtAddr), .bcastMaskEn(bcastMaskEn), .ctlMaskBcast(ctlMaskBcast),
    .isBcastMsg(isBcastMsg), .msgDone(msgDone), .irqOpStb(irqOpStb),
    .irqOpParam(irqOpParam), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic sendSts(input logic [15:0] w);
    stsWord = w; stsValid = 1'b1;
    step();
    stsValid = 1'b0;
  endtask

  function automatic logic expectBad(input logic [15:0] w, input logic [4:0] ca,
                                     input logic cfg, input logic cm);
    logic bad;
    bad = (w[15:11] != ca) || w[10] || w[9] || w[8] || w[3] || w[2] || w[1] || w[0];
    if (!cfg && (w[4] != cm)) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic [15:0] flagsOf(input logic [15:0] raw);
    return raw | {15'd0, (raw[15:3] != 0)};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    logic        bad, merr;

    repeat (3) step();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset read", v, 16'h0000);
    end
    chk("R1 reset irqOut", {15'd0, irqOut}, 16'h0000);
    rstN = 1'b1;
    step();

    // R11 writable fields
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R11 enable mask", v, 16'h03F8);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R11 outen mask", v, 16'h03F8);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R11 flags idle", v, 16'h0000);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R11 addr3 read", v, 16'h0000);
    wr(2'd2, 16'h0000);

    // R3 R4 R5 R10 sweep over flag bits, reserved bits, config and control bit
    cmdRtAddr = 5'h0A;
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int cm = 0; cm < 2; cm++) begin
        for (int p = 0; p < 256; p++) begin
          bcastMaskEn = cfg[0]; ctlMaskBcast = cm[0];
          w = {5'h0A, p[7], p[6], p[5], p[2:0], p[4], p[3], p[2], p[1], p[0]};
          bad  = expectBad(w, 5'h0A, cfg[0], cm[0]);
          merr = w[10];
          sendSts(w);
          rd(2'd0, v);
          chk("R3 R4 R5 R10 status sweep", v,
              flagsOf({6'd0, bad, 4'd0, merr, 4'd0}));
          wr(2'd0, 16'hFFFF);
        end
      end
    end

    // R2 address sweep
    bcastMaskEn = 1'b1;
    for (int ca = 0; ca < 32; ca++) begin
      for (int ra = 0; ra < 32; ra++) begin
        cmdRtAddr = 5'(ca);
        sendSts({5'(ra), 11'd0});
        rd(2'd0, v);
        chk("R2 address compare", v, (ca != ra) ? 16'h0201 : 16'h0000);
        wr(2'd0, 16'hFFFF);
      end
    end

    // R5 broadcast suppresses message error
    cmdRtAddr = 5'h03;
    isBcastMsg = 1'b1;
    sendSts({5'h03, 1'b1, 10'd0});
    rd(2'd0, v); chk("R5 broadcast merr", v, 16'h0201);
    wr(2'd0, 16'hFFFF);
    isBcastMsg = 1'b0;
    sendSts({5'h03, 1'b1, 10'd0});
    rd(2'd0, v); chk("R5 directed merr", v, 16'h0211);
    wr(2'd0, 16'hFFFF);

    // R6 end of message
    msgDone = 1'b1; step(); msgDone = 1'b0;
    rd(2'd0, v); chk("R6 eom", v, 16'h0009);
    wr(2'd0, 16'hFFFF);

    // R7 IRQ code sweep and overwrite
    for (int c = 0; c < 16; c++) begin
      irqOpParam = 4'(c); irqOpStb = 1'b1; step(); irqOpStb = 1'b0;
      rd(2'd0, v);
      chk("R7 code load", v, flagsOf(16'(c) << 5));
      wr(2'd0, 16'hFFFF);
    end
    irqOpParam = 4'hA; irqOpStb = 1'b1; step();
    irqOpParam = 4'h5; step(); irqOpStb = 1'b0;
    rd(2'd0, v); chk("R7 code overwrite", v, 16'h00A1);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h03B8);
    irqOpParam = 4'hF; irqOpStb = 1'b1; step(); irqOpStb = 1'b0;
    rd(2'd0, v); chk("R7 R8 code gated", v, 16'h01A1);
    wr(2'd0, 16'hFFFF);

    // R8 enable gating
    wr(2'd1, 16'h0000);
    msgDone = 1'b1; stsWord = {5'h1F, 1'b1, 10'd0}; stsValid = 1'b1;
    irqOpParam = 4'hF; irqOpStb = 1'b1;
    step();
    msgDone = 1'b0; stsValid = 1'b0; irqOpStb = 1'b0;
    rd(2'd0, v); chk("R8 all disabled", v, 16'h0000);
    wr(2'd1, 16'h0008);
    msgDone = 1'b1; stsValid = 1'b1; irqOpStb = 1'b1;
    step();
    msgDone = 1'b0; stsValid = 1'b0; irqOpStb = 1'b0;
    rd(2'd0, v); chk("R8 eom only", v, 16'h0009);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h03F8);

    // R9 sticky and write-one-to-clear
    cmdRtAddr = 5'h03;
    msgDone = 1'b1; stsWord = {5'h03, 1'b1, 10'd0}; stsValid = 1'b1;
    step();
    msgDone = 1'b0; stsValid = 1'b0;
    repeat (5) step();
    rd(2'd0, v); chk("R9 sticky", v, 16'h0219);
    wr(2'd0, 16'h0008);
    rd(2'd0, v); chk("R9 clear one bit", v, 16'h0211);
    regWe = 1'b1; regAddr = 2'd0; regWdata = 16'h0008; msgDone = 1'b1;
    step();
    regWe = 1'b0; msgDone = 1'b0;
    rd(2'd0, v); chk("R9 set beats clear", v, 16'h0219);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R9 R10 all cleared", v, 16'h0000);

    // R12 output gating sweep over each live bit
    msgDone = 1'b1; step(); msgDone = 1'b0;
    for (int b = 3; b <= 9; b++) begin
      wr(2'd2, 16'(1) << b);
      #1;
      chk("R12 irqOut gate", {15'd0, irqOut}, (b == 3) ? 16'h0001 : 16'h0000);
    end
    wr(2'd2, 16'h0008);
    wr(2'd0, 16'h0008);
    #1;
    chk("R12 irqOut after clear", {15'd0, irqOut}, 16'h0000);

    finishRun();
  end
endmodule